// File: doc/BRIEF.md
# Attribute-to-DAC Index Colour Mapper

This block sits between the pixel pipeline of a character/planar display engine and the colour lookup RAM. Each incoming beat carries one pixel: a byte whose low four bits are the pixel's colour attribute (or, in 8-bit-pixel mode, the whole byte is the colour), a flag telling whether the pixel belongs to a glyph foreground, the blink bit of the character attribute, the character's background colour, and a flag marking border pixels. The mapper masks disabled colour planes, applies blink substitution, looks the result up in a sixteen-entry palette of 6-bit values and composes the final 8-bit DAC index from the palette entry and a colour-select register.

Both data sides are valid/ready streams. A beat is taken when `in_valid` and `in_ready` are both high at a rising edge; the mapped index appears on `out_idx` with `out_valid` on the following cycle. While `out_valid` is high and `out_ready` is low the output holds its value and `in_ready` drops, so back-pressure reaches the pixel source at once; the stage sustains one pixel per cycle while `out_ready` stays high. Configuration registers are loaded through a plain write port (`cfg_we`, `cfg_addr`, `cfg_wdata`); a write takes effect for beats accepted from the next cycle on. `disp_en` and `blink_phase` are plain level inputs sampled with each accepted beat.

Top module: `attr_map_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1; all palette entries, the mode register, overscan register and colour-select register are 0, and the plane-enable register is 4'hF.
- R2: With mode bits 7 and 6 clear, the output index is {csel[3:2], pal[c][5:0]} where c is the masked, blink-processed 4-bit colour and csel is the colour-select register (address 20).
- R3: With mode bit 7 set (mode register at address 16), output bits 5:4 come from csel[1:0] instead of palette bits 5:4; bits 7:6 and 3:0 are as in R2.
- R4: Bit k of the plane-enable register (address 18, bits 3:0) gates bit k of the pixel colour and of the background colour; a disabled bit is zero before the lookup.
- R5: With mode bit 3 set and `blink_phase` low, a background pixel (`in_fg`=0) has colour bit 3 cleared and a foreground pixel whose `in_blink` is set takes the masked background colour with bit 3 cleared; with `blink_phase` high, or mode bit 3 clear, the colour passes unchanged.
- R6: A beat with `in_border` set outputs the overscan register (address 17) composed like a palette entry (R2/R3 rules on its bits 5:0).
- R7: While `disp_en` is low every accepted beat outputs the overscan colour as in R6, regardless of the pixel fields.
- R8: With mode bit 6 set, a non-border beat outputs `in_byte` unchanged, ignoring plane enable, palette and colour select; a border or display-disabled beat outputs all 8 bits of the overscan register.
- R9: Palette writes (addresses 0 to 15, data bits 5:0) are ignored while `disp_en` is high; writes to the other registers are accepted at any time; other addresses are ignored.
- R10: A beat accepted at edge N is presented on `out_idx` with `out_valid` high after edge N, in order, one cycle of latency.
- R11: While `out_valid` is high and `out_ready` low, `out_valid` and `out_idx` stay unchanged and `in_ready` is low; with `out_valid` low, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address (0-15 palette, 16 mode, 17 overscan, 18 plane enable, 20 colour select) |
| cfg_wdata | input | 8 | Register write data |
| disp_en | input | 1 | Screen output enable; low forces overscan and unlocks palette writes |
| blink_phase | input | 1 | Current blink phase, high = visible |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_byte | input | 8 | Pixel byte; bits 3:0 colour, or full colour in 8-bit mode |
| in_fg | input | 1 | Pixel is glyph foreground |
| in_blink | input | 1 | Character attribute blink bit |
| in_bg | input | 4 | Character background colour |
| in_border | input | 1 | Pixel lies in the border |
| out_valid | output | 1 | Output index valid |
| out_ready | input | 1 | Downstream accepts the output index |
| out_idx | output | 8 | Registered DAC index |

## Verification
The hardest case to reach is the blink substitution, which needs mode bit 3 set, `blink_phase` low, and a foreground pixel carrying the blink flag whose background colour differs from its own, all with planes partly masked; the stimulus programs a palette whose entries are all distinct, so a wrong substitution, a missed mask or a swapped bit field shows as a different index. The palette lock is reached by writing one entry with the display on and then again with it off, reading the effect back through a pixel of that colour. Back-pressure is exercised by a pseudo-random `out_ready` pattern while a stream of mixed pixels runs, checking that stalled outputs hold.

// File: rtl/attr_map_pkg.sv
package attr_map_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_MODE  = 5'd16;
  localparam logic [ADDR_W-1:0] A_OVSC  = 5'd17;
  localparam logic [ADDR_W-1:0] A_PLANE = 5'd18;
  localparam logic [ADDR_W-1:0] A_CSEL  = 5'd20;

  localparam int M_BLINK = 3;
  localparam int M_BYTE  = 6;
  localparam int M_CSEL  = 7;

  typedef struct packed {
    logic [7:0] mode;
    logic [7:0] ovsc;
    logic [3:0] plane;
    logic [3:0] csel;
  } cfg_t;
endpackage

// File: rtl/attr_map_regs.sv
module attr_map_regs
  import attr_map_pkg::*;
#(
  parameter int ATTR_W = 4,
  parameter int PAL_W  = 6,
  localparam int NENT  = 1 << ATTR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  logic                  disp_en,
  output logic [NENT*PAL_W-1:0] pal_flat,
  output cfg_t                  cfg
);
  // palette entries: writable only while the screen is off
  for (genvar e = 0; e < NENT; e++) begin : g_pal
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pal_flat[e*PAL_W +: PAL_W] <= '0;
      end else if (cfg_we && !disp_en && cfg_addr == ADDR_W'(e)) begin
        pal_flat[e*PAL_W +: PAL_W] <= cfg_wdata[PAL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.mode  <= '0;
      cfg.ovsc  <= '0;
      cfg.plane <= '1;
      cfg.csel  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_MODE:  cfg.mode  <= cfg_wdata;
        A_OVSC:  cfg.ovsc  <= cfg_wdata;
        A_PLANE: cfg.plane <= cfg_wdata[3:0];
        A_CSEL:  cfg.csel  <= cfg_wdata[3:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/attr_map_colour.sv
module attr_map_colour
  import attr_map_pkg::*;
#(
  parameter int ATTR_W = 4,
  parameter int PAL_W  = 6,
  parameter int IDX_W  = 8,
  localparam int NENT  = 1 << ATTR_W
) (
  input  logic [IDX_W-1:0]      in_byte,
  input  logic                  in_fg,
  input  logic                  in_blink,
  input  logic [ATTR_W-1:0]     in_bg,
  input  logic                  in_border,
  input  logic                  disp_en,
  input  logic                  blink_phase,
  input  logic [NENT*PAL_W-1:0] pal_flat,
  input  cfg_t                  cfg,
  output logic [IDX_W-1:0]      idx
);
  logic [ATTR_W-1:0] fg_m, bg_m, col;
  logic [PAL_W-1:0]  pal_val, src_val;
  logic [IDX_W-1:0]  composed;
  logic              use_ovsc;

  // stage 1: plane masking
  assign fg_m = in_byte[ATTR_W-1:0] & cfg.plane;
  assign bg_m = in_bg & cfg.plane;

  // stage 2: blink substitution during the dark phase
  always_comb begin
    col = fg_m;
    if (cfg.mode[M_BLINK] && !blink_phase) begin
      if (!in_fg) begin
        col[ATTR_W-1] = 1'b0;
      end else if (in_blink) begin
        col = {1'b0, bg_m[ATTR_W-2:0]};
      end
    end
  end

  // stage 3: palette lookup
  assign pal_val  = pal_flat[col*PAL_W +: PAL_W];
  assign use_ovsc = in_border || !disp_en;
  assign src_val  = use_ovsc ? cfg.ovsc[PAL_W-1:0] : pal_val;

  // stage 4: upper index bits from palette or colour select
  always_comb begin
    composed = '0;
    composed[3:0] = src_val[3:0];
    composed[5:4] = cfg.mode[M_CSEL] ? cfg.csel[1:0] : src_val[5:4];
    composed[7:6] = cfg.csel[3:2];
  end

  always_comb begin
    if (cfg.mode[M_BYTE]) begin
      idx = use_ovsc ? cfg.ovsc : in_byte;
    end else begin
      idx = composed;
    end
  end
endmodule

// File: rtl/attr_map_stage.sv
module attr_map_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= in_data;
    end
  end
endmodule

// File: rtl/attr_map_top.sv
module attr_map_top
  import attr_map_pkg::*;
#(
  parameter int ATTR_W = 4,
  parameter int PAL_W  = 6,
  parameter int IDX_W  = 8,
  localparam int NENT  = 1 << ATTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              disp_en,
  input  logic              blink_phase,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_byte,
  input  logic              in_fg,
  input  logic              in_blink,
  input  logic [ATTR_W-1:0] in_bg,
  input  logic              in_border,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx
);
  logic [NENT*PAL_W-1:0] pal_flat;
  cfg_t                  cfg_q;
  logic [IDX_W-1:0]      idx_c;

  attr_map_regs #(.ATTR_W(ATTR_W), .PAL_W(PAL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .disp_en(disp_en), .pal_flat(pal_flat), .cfg(cfg_q)
  );

  attr_map_colour #(.ATTR_W(ATTR_W), .PAL_W(PAL_W), .IDX_W(IDX_W)) colour_i (
    .in_byte(in_byte), .in_fg(in_fg), .in_blink(in_blink), .in_bg(in_bg),
    .in_border(in_border), .disp_en(disp_en), .blink_phase(blink_phase),
    .pal_flat(pal_flat), .cfg(cfg_q), .idx(idx_c)
  );

  attr_map_stage #(.W(IDX_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(idx_c), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_idx)
  );
endmodule

// File: rtl/attr_map_chk.sv
module attr_map_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDX_W-1:0] in_byte,
  input logic             in_border,
  input logic             disp_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx,
  input logic             byte_mode,
  input logic [7:0]       ovsc
);
  // R10: an accepted beat shows up as valid output on the next cycle
  a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11: a stalled output holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx)));

  // R11: an empty stage never refuses input
  a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8: byte mode passes the pixel byte straight through
  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && byte_mode && !in_border && disp_en)
      |=> (out_idx == $past(in_byte)));

  // R7: a dark screen in byte mode emits the full overscan byte
  a_r7_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && byte_mode && !disp_en)
      |=> (out_idx == $past(ovsc)));
endmodule

bind attr_map_top attr_map_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .in_border(in_border), .disp_en(disp_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
  .byte_mode(cfg_q.mode[6]), .ovsc(cfg_q.ovsc)
);

// File: tb/attr_map_top_tb_top.sv
module attr_map_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       disp_en = 1'b0;
  logic       blink_phase = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = '0;
  logic       in_fg = 1'b0;
  logic       in_blink = 1'b0;
  logic [3:0] in_bg = '0;
  logic       in_border = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_idx;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] expq[$];
  string      tagq[$];

  logic [5:0] sh_pal [16];
  logic [7:0] sh_mode = '0, sh_ovs = '0;
  logic [3:0] sh_pe = 4'hF, sh_cs = '0;

  logic        stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        hold_chk = 1'b0;
  logic [7:0]  held = '0;

  always #10 clk = ~clk;

  attr_map_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .disp_en(disp_en), .blink_phase(blink_phase),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .in_fg(in_fg), .in_blink(in_blink), .in_bg(in_bg), .in_border(in_border),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] compose(input logic [5:0] p);
    return {sh_cs[3:2], (sh_mode[7] ? sh_cs[1:0] : p[5:4]), p[3:0]};
  endfunction

  function automatic logic [7:0] model(input logic [7:0] b, input logic fg,
                                       input logic bl, input logic [3:0] bg,
                                       input logic brd);
    logic [3:0] c, g;
    if (brd || !disp_en) return sh_mode[6] ? sh_ovs : compose(sh_ovs[5:0]);
    if (sh_mode[6]) return b;
    c = b[3:0] & sh_pe;
    g = bg & sh_pe;
    if (sh_mode[3] && !blink_phase) begin
      if (!fg) c[3] = 1'b0;
      else if (bl) c = {1'b0, g[2:0]};
    end
    return compose(sh_pal[c]);
  endfunction

  // called right after a rising edge
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a < 5'd16) begin
      if (!disp_en) sh_pal[a] = d[5:0];
    end else if (a == 5'd16) sh_mode = d;
    else if (a == 5'd17) sh_ovs = d;
    else if (a == 5'd18) sh_pe = d[3:0];
    else if (a == 5'd20) sh_cs = d[3:0];
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic fg, input logic bl,
                      input logic [3:0] bg, input logic brd, input string tag);
    in_valid = 1'b1; in_byte = b; in_fg = fg; in_blink = bl; in_bg = bg; in_border = brd;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    expq.push_back(model(b, fg, bl, bg, brd));
    tagq.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // back-pressure generator
  always @(posedge clk) begin
    #1;
    if (stall_en) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
    end else begin
      out_ready = 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_chk) check(out_valid && out_idx == held, "R11 hold", out_idx, held);
      if (out_valid && !out_ready) check(!in_ready, "R11 in_ready", in_ready, 0);
      hold_chk = out_valid && !out_ready;
      held = out_idx;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10 unexpected output", out_idx, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(out_idx == e, t, out_idx, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) sh_pal[i] = '0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", out_valid, 0);
    check(in_ready, "R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);
    disp_en = 1'b1;
    send(8'h0A, 1, 0, 4'h0, 0, "R1 default palette");
    send(8'h07, 1, 0, 4'h0, 1, "R1 default overscan");
    idle(2);

    // load distinct palette with the screen off
    disp_en = 1'b0;
    for (int i = 0; i < 16; i++) wr(5'(i), 8'((i * 7 + 5) & 63));
    wr(5'd20, 8'h0B);
    wr(5'd17, 8'h2D);
    disp_en = 1'b1;

    for (int i = 0; i < 16; i++) send(8'(i), 1, 0, 4'h0, 0, "R2 lookup");
    send(8'hF3, 0, 0, 4'h5, 0, "R2 upper nibble ignored");

    wr(5'd16, 8'h80);
    for (int i = 0; i < 16; i += 3) send(8'(i), 1, 0, 4'h0, 0, "R3 csel override");
    wr(5'd16, 8'h00);

    wr(5'd18, 8'h05);
    send(8'h0F, 1, 0, 4'h0, 0, "R4 mask 0F");
    send(8'h0A, 1, 0, 4'h0, 0, "R4 mask 0A");
    wr(5'd18, 8'h03);
    send(8'h0E, 1, 0, 4'h0, 0, "R4 mask 0E");
    wr(5'd18, 8'h0F);

    wr(5'd16, 8'h08);
    blink_phase = 1'b0;
    send(8'h0C, 0, 0, 4'hC, 0, "R5 bg intensity cleared");
    send(8'h09, 1, 1, 4'hE, 0, "R5 blink fg replaced");
    send(8'h09, 1, 0, 4'hE, 0, "R5 non-blink fg kept");
    wr(5'd18, 8'h0B);
    send(8'h0D, 1, 1, 4'hE, 0, "R5 masked bg substitution");
    wr(5'd18, 8'h0F);
    blink_phase = 1'b1;
    send(8'h0C, 0, 0, 4'hC, 0, "R5 visible phase bg");
    send(8'h09, 1, 1, 4'hE, 0, "R5 visible phase fg");
    wr(5'd16, 8'h00);
    blink_phase = 1'b0;
    send(8'h0C, 0, 0, 4'hC, 0, "R5 blink mode off");
    send(8'h09, 1, 1, 4'hE, 0, "R5 blink mode off fg");
    blink_phase = 1'b1;

    send(8'h03, 1, 0, 4'h0, 1, "R6 border");
    wr(5'd16, 8'h80);
    send(8'h03, 1, 0, 4'h0, 1, "R6 border csel");
    wr(5'd16, 8'h00);

    disp_en = 1'b0;
    send(8'h04, 1, 0, 4'h0, 0, "R7 screen off");
    send(8'h0B, 0, 0, 4'h2, 0, "R7 screen off bg");
    disp_en = 1'b1;

    wr(5'd17, 8'hE7);
    wr(5'd16, 8'h40);
    wr(5'd18, 8'h00);
    send(8'hC3, 1, 0, 4'h0, 0, "R8 byte pass");
    send(8'h5A, 0, 1, 4'h0, 0, "R8 byte pass 2");
    send(8'h11, 1, 0, 4'h0, 1, "R8 border byte");
    disp_en = 1'b0;
    send(8'h22, 1, 0, 4'h0, 0, "R8 dark byte");
    disp_en = 1'b1;
    wr(5'd18, 8'h0F);
    wr(5'd16, 8'h00);

    // R9: palette lock while the screen is on
    wr(5'd5, 8'h22);
    send(8'h05, 1, 0, 4'h0, 0, "R9 locked write ignored");
    wr(5'd19, 8'hFF);
    wr(5'd21, 8'hFF);
    send(8'h05, 1, 0, 4'h0, 0, "R9 unused address ignored");
    disp_en = 1'b0;
    wr(5'd5, 8'h22);
    disp_en = 1'b1;
    send(8'h05, 1, 0, 4'h0, 0, "R9 unlocked write");
    idle(3);

    // R10 latency: accepted now, valid after the next edge
    send(8'h06, 1, 0, 4'h0, 0, "R10 data");
    @(negedge clk);
    check(out_valid, "R10 latency", out_valid, 1);
    idle(3);

    // R11 back-pressure with a mixed stream
    stall_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (i == 20) wr(5'd16, 8'h88);
      if (i == 40) wr(5'd16, 8'h40);
      blink_phase = i[2];
      send(8'((i * 37) & 255), i[0], i[1], 4'(i * 5), (i % 11) == 0, "R11 stream");
    end
    stall_en = 1'b0;
    idle(5);
    check(expq.size() == 0, "R10 drained", expq.size(), 0);
    summary();
    $finish;
  end
endmodule